// File: doc/BRIEF.md
# Packed Double-Precision Pair Shuffle Unit

This block is a purely combinational datapath that builds a 512-bit result vector of eight 64-bit elements from two 512-bit source vectors. Each destination element picks one of two elements inside a single 128-bit lane, using one immediate bit. Even destination slots draw from source A and odd slots from source B. The data is only moved and is never interpreted as floating point.

The surrounding pipeline supplies a mode code and a length code. The block then applies the rule for that mode to the bits above the active length: they either keep the old destination value or are cleared. In the masked mode, an 8-bit write mask can leave individual elements unwritten, and each unwritten element either keeps its old value (merging) or is cleared (zeroing). A broadcast flag in the masked mode replaces every element of source B with source B element 0. A mode and length pair that is not supported returns the old destination unchanged.

Top module: `pd_pair_shuffle`

## Requirements
- R1: Destination element 2k equals source A element 2k when immediate bit 2k is 0, and source A element 2k+1 when that bit is 1 (k is the 128-bit lane index). Element e occupies bits [64e+63:64e].
- R2: Destination element 2k+1 equals source B element 2k when immediate bit 2k+1 is 0, and source B element 2k+1 when it is 1.
- R3: Only immediate bits 0 to KL-1 influence the result. KL is 2 for length code 0 (128 bits), 4 for code 1 (256 bits) and 8 for code 2 (512 bits).
- R4: In the masked mode (mode code 3), an element below KL is written with its shuffled value when its mask bit is 1 or when the mask-enable input is 0.
- R5: In the masked mode, with mask enable at 1, an element below KL whose mask bit is 0 keeps its old destination value when the zeroing input is 0, and becomes zero when the zeroing input is 1.
- R6: Mask bits KL to 7 have no effect on the result.
- R7: In the masked mode, when the broadcast input is 1, every element of source B is replaced by source B element 0 before selection. In the other modes the broadcast input has no effect.
- R8: In the masked mode and in the plain 128-bit mode (mode code 1), every destination bit at or above 64·KL is zero.
- R9: In the legacy 128-bit mode (mode code 0), destination bits 511:128 equal the old destination.
- R10: In the plain 256-bit mode (mode code 2), bits 511:256 equal the old destination, and elements 0 to 3 are always written whatever the mask, zeroing and broadcast inputs are.
- R11: The result equals the old destination when the length code is 3, when mode 0 or mode 1 is given a length code other than 0, or when mode 2 is given a length code other than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 512 | Source A; supplies the even destination slots |
| src_b_i | input | 512 | Source B; supplies the odd destination slots |
| old_dst_i | input | 512 | Current destination value, used for merge and keep |
| imm_i | input | 8 | Per-element select bits |
| wmask_i | input | 8 | Per-element write mask (masked mode) |
| mask_en_i | input | 1 | 1 = apply the write mask |
| zero_en_i | input | 1 | 1 = clear unwritten elements, 0 = merge |
| bcast_i | input | 1 | 1 = broadcast source B element 0 (masked mode) |
| len_i | input | 2 | Length code: 0=128, 1=256, 2=512, 3=reserved |
| mode_i | input | 2 | 0=legacy 128, 1=plain 128, 2=plain 256, 3=masked |
| dst_o | output | 512 | New destination vector |

## Verification
Every element in the source data is distinct and random, so an output element that comes from the wrong lane, the wrong half or the wrong source cannot match by chance. Immediates 0x00 and 0xFF force every slot to its low half or its high half, which shows whether the even and odd select paths are swapped. All-zero masks under both merging and zeroing, and masks that are set only above KL, show whether the mask gating and the upper-bit rule are applied independently. Broadcast in masked and non-masked modes, and the unsupported mode and length pairs, show that the mode decode confines each feature to the cases where it applies.

// File: rtl/pd_shuf_pkg.sv
// Shared encodings for the pair shuffle unit.
// Assumes mode and length codes are driven as 2-bit fields by the issuing stage.
package pd_shuf_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY128 = 2'd0,
        MODE_PLAIN128  = 2'd1,
        MODE_PLAIN256  = 2'd2,
        MODE_MASKED    = 2'd3
    } shuf_mode_e;

    typedef enum logic [1:0] {
        LEN_128  = 2'd0,
        LEN_256  = 2'd1,
        LEN_512  = 2'd2,
        LEN_RSVD = 2'd3
    } vec_len_e;

    typedef enum logic [1:0] {
        ACT_SHUF = 2'd0,
        ACT_KEEP = 2'd1,
        ACT_ZERO = 2'd2
    } elem_act_e;

endpackage

// File: rtl/pd_shuf_ctrl.sv
// Mode and length decode: produces one action per destination element
// (shuffle, keep old, clear) and the gated broadcast enable.
// Assumes NUM_ELEM >= 8 so that the 512-bit length code fits the vector.
module pd_shuf_ctrl
    import pd_shuf_pkg::*;
#(
    parameter int NUM_ELEM = 8
) (
    input  logic [1:0]                     mode_i,
    input  logic [1:0]                     len_i,
    input  logic [NUM_ELEM-1:0]            wmask_i,
    input  logic                           mask_en_i,
    input  logic                           zero_en_i,
    input  logic                           bcast_i,
    output elem_act_e [NUM_ELEM-1:0]       act_o,
    output logic                           bcast_eff_o
);
    localparam int KL_W = $clog2(NUM_ELEM) + 2;

    shuf_mode_e      mode;
    vec_len_e        len;
    logic            supported;
    logic            masked;
    elem_act_e       above_act;
    logic [KL_W-1:0] kl;

    assign mode = shuf_mode_e'(mode_i);
    assign len  = vec_len_e'(len_i);

    // Decode support, active element count and the rule above the length.
    always_comb begin
        supported = 1'b0;
        masked    = 1'b0;
        above_act = ACT_KEEP;
        kl        = KL_W'(2);
        case (mode)
            MODE_LEGACY128: begin
                supported = (len == LEN_128);
                above_act = ACT_KEEP;
            end
            MODE_PLAIN128: begin
                supported = (len == LEN_128);
                above_act = ACT_ZERO;
            end
            MODE_PLAIN256: begin
                supported = (len == LEN_256);
                above_act = ACT_KEEP;
                kl        = KL_W'(4);
            end
            default: begin
                supported = (len != LEN_RSVD);
                masked    = 1'b1;
                above_act = ACT_ZERO;
                kl        = KL_W'(2) << len_i;
            end
        endcase
    end

    // Broadcast only reaches the datapath in the masked mode.
    assign bcast_eff_o = bcast_i && masked && supported;

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem_act
        logic in_range;
        assign in_range = (KL_W'(e) < kl);

        // Pick this element's action from support, range and mask.
        always_comb begin
            if (!supported)
                act_o[e] = ACT_KEEP;
            else if (!in_range)
                act_o[e] = above_act;
            else if (masked && mask_en_i && !wmask_i[e])
                act_o[e] = zero_en_i ? ACT_ZERO : ACT_KEEP;
            else
                act_o[e] = ACT_SHUF;
        end
    end

endmodule

// File: rtl/pd_shuf_src_prep.sv
// Source B preparation: optionally replicates element 0 across all slots.
// Assumes the broadcast enable is already gated by mode.
module pd_shuf_src_prep #(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8
) (
    input  logic [ELEM_W*NUM_ELEM-1:0] src_b_i,
    input  logic                       bcast_i,
    output logic [ELEM_W*NUM_ELEM-1:0] src_b_o
);
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_bcast
        // Each slot takes either its own element or element 0.
        assign src_b_o[e*ELEM_W +: ELEM_W] =
            bcast_i ? src_b_i[ELEM_W-1:0] : src_b_i[e*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/pd_shuf_lane_pick.sv
// In-lane selection: each 128-bit lane yields an even slot from source A and
// an odd slot from source B, each picked by its own immediate bit.
// Assumes NUM_ELEM is even.
module pd_shuf_lane_pick #(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8
) (
    input  logic [ELEM_W*NUM_ELEM-1:0] src_a_i,
    input  logic [ELEM_W*NUM_ELEM-1:0] src_b_i,
    input  logic [NUM_ELEM-1:0]        imm_i,
    output logic [ELEM_W*NUM_ELEM-1:0] pick_o
);
    localparam int NUM_LANE = NUM_ELEM / 2;
    localparam int LANE_W   = 2 * ELEM_W;

    for (genvar k = 0; k < NUM_LANE; k++) begin : g_lane
        logic [ELEM_W-1:0] a_lo, a_hi, b_lo, b_hi;
        assign a_lo = src_a_i[k*LANE_W          +: ELEM_W];
        assign a_hi = src_a_i[k*LANE_W + ELEM_W +: ELEM_W];
        assign b_lo = src_b_i[k*LANE_W          +: ELEM_W];
        assign b_hi = src_b_i[k*LANE_W + ELEM_W +: ELEM_W];

        // Even slot of lane k chooses within source A.
        assign pick_o[k*LANE_W +: ELEM_W] = imm_i[2*k] ? a_hi : a_lo;
        // Odd slot of lane k chooses within source B.
        assign pick_o[k*LANE_W + ELEM_W +: ELEM_W] = imm_i[2*k+1] ? b_hi : b_lo;
    end

endmodule

// File: rtl/pd_shuf_writeback.sv
// Per-element final multiplexer: shuffled value, old value or zero.
// Assumes the action vector has been decoded to known codes.
module pd_shuf_writeback
    import pd_shuf_pkg::*;
#(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8
) (
    input  logic [ELEM_W*NUM_ELEM-1:0] pick_i,
    input  logic [ELEM_W*NUM_ELEM-1:0] old_dst_i,
    input  elem_act_e [NUM_ELEM-1:0]   act_i,
    output logic [ELEM_W*NUM_ELEM-1:0] dst_o
);
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_wb
        // Resolve this element's value from its action.
        always_comb begin
            case (act_i[e])
                ACT_SHUF: dst_o[e*ELEM_W +: ELEM_W] = pick_i[e*ELEM_W +: ELEM_W];
                ACT_ZERO: dst_o[e*ELEM_W +: ELEM_W] = '0;
                default:  dst_o[e*ELEM_W +: ELEM_W] = old_dst_i[e*ELEM_W +: ELEM_W];
            endcase
        end
    end

endmodule

// File: rtl/pd_pair_shuffle.sv
// Top of the packed pair shuffle: decode, source B preparation, in-lane
// selection and per-element write-back. Purely combinational.
// Assumes ELEM_W*NUM_ELEM is the full register width and NUM_ELEM >= 8.
module pd_pair_shuffle
    import pd_shuf_pkg::*;
#(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8,
    localparam int VEC_W   = ELEM_W * NUM_ELEM
) (
    input  logic [VEC_W-1:0]    src_a_i,
    input  logic [VEC_W-1:0]    src_b_i,
    input  logic [VEC_W-1:0]    old_dst_i,
    input  logic [NUM_ELEM-1:0] imm_i,
    input  logic [NUM_ELEM-1:0] wmask_i,
    input  logic                mask_en_i,
    input  logic                zero_en_i,
    input  logic                bcast_i,
    input  logic [1:0]          len_i,
    input  logic [1:0]          mode_i,
    output logic [VEC_W-1:0]    dst_o
);
    elem_act_e [NUM_ELEM-1:0] act;
    logic                     bcast_eff;
    logic [VEC_W-1:0]         src_b_eff;
    logic [VEC_W-1:0]         pick;

    pd_shuf_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
        .mode_i      (mode_i),
        .len_i       (len_i),
        .wmask_i     (wmask_i),
        .mask_en_i   (mask_en_i),
        .zero_en_i   (zero_en_i),
        .bcast_i     (bcast_i),
        .act_o       (act),
        .bcast_eff_o (bcast_eff)
    );

    pd_shuf_src_prep #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_src_prep (
        .src_b_i (src_b_i),
        .bcast_i (bcast_eff),
        .src_b_o (src_b_eff)
    );

    pd_shuf_lane_pick #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_lane_pick (
        .src_a_i (src_a_i),
        .src_b_i (src_b_eff),
        .imm_i   (imm_i),
        .pick_o  (pick)
    );

    pd_shuf_writeback #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_writeback (
        .pick_i    (pick),
        .old_dst_i (old_dst_i),
        .act_i     (act),
        .dst_o     (dst_o)
    );

endmodule

// File: rtl/pd_pair_shuffle_chk.sv
// Assertion checker bound to the pair shuffle top. The block has no clock,
// so the checks are immediate assertions on the settled port values.
module pd_pair_shuffle_chk #(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8,
    localparam int VEC_W   = ELEM_W * NUM_ELEM,
    localparam int LANE_W  = 2 * ELEM_W
) (
    input logic [LANE_W-1:0]   src_a_lo,
    input logic [LANE_W-1:0]   src_b_lo,
    input logic [VEC_W-1:0]    old_dst_i,
    input logic [1:0]          imm_lo,
    input logic [NUM_ELEM-1:0] wmask_i,
    input logic                mask_en_i,
    input logic                zero_en_i,
    input logic                bcast_i,
    input logic [1:0]          len_i,
    input logic [1:0]          mode_i,
    input logic [VEC_W-1:0]    dst_o
);
    logic sup;
    logic elem0_written, elem1_written;
    logic [ELEM_W-1:0] exp0, exp1;

    // Whether the mode and length pair is a supported one.
    always_comb begin
        case (mode_i)
            2'd0, 2'd1: sup = (len_i == 2'd0);
            2'd2:       sup = (len_i == 2'd1);
            default:    sup = (len_i != 2'd3);
        endcase
    end

    assign elem0_written = sup && ((mode_i != 2'd3) || !mask_en_i || wmask_i[0]);
    assign elem1_written = sup && ((mode_i != 2'd3) || !mask_en_i || wmask_i[1]);
    assign exp0 = imm_lo[0] ? src_a_lo[LANE_W-1:ELEM_W] : src_a_lo[ELEM_W-1:0];
    assign exp1 = (mode_i == 2'd3 && bcast_i) ? src_b_lo[ELEM_W-1:0] :
                  (imm_lo[1] ? src_b_lo[LANE_W-1:ELEM_W] : src_b_lo[ELEM_W-1:0]);

    // Check the port-level rules once the inputs have settled.
    always_comb begin
        if (sup && mode_i == 2'd1)
            assert_plain128_upper_clear_R8: assert (dst_o[VEC_W-1:LANE_W] == '0);
        if (sup && mode_i == 2'd0)
            assert_legacy_upper_keep_R9: assert (dst_o[VEC_W-1:LANE_W] == old_dst_i[VEC_W-1:LANE_W]);
        if (sup && mode_i == 2'd2)
            assert_plain256_upper_keep_R10: assert (dst_o[VEC_W-1:2*LANE_W] == old_dst_i[VEC_W-1:2*LANE_W]);
        if (!sup)
            assert_unsupported_passthru_R11: assert (dst_o == old_dst_i);
        if (sup && mode_i == 2'd3 && mask_en_i && zero_en_i && wmask_i == '0)
            assert_all_masked_zero_R5: assert (dst_o == '0);
        if (elem0_written)
            assert_even_slot_pick_R1: assert (dst_o[ELEM_W-1:0] == exp0);
        if (elem1_written)
            assert_odd_slot_pick_R2: assert (dst_o[LANE_W-1:ELEM_W] == exp1);
    end

endmodule

bind pd_pair_shuffle pd_pair_shuffle_chk #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_chk (
    .src_a_lo  (src_a_i[2*ELEM_W-1:0]),
    .src_b_lo  (src_b_i[2*ELEM_W-1:0]),
    .old_dst_i (old_dst_i),
    .imm_lo    (imm_i[1:0]),
    .wmask_i   (wmask_i),
    .mask_en_i (mask_en_i),
    .zero_en_i (zero_en_i),
    .bcast_i   (bcast_i),
    .len_i     (len_i),
    .mode_i    (mode_i),
    .dst_o     (dst_o)
);

// File: tb/pd_pair_shuffle_tb.sv
// Self-checking bench: random and directed stimulus compared with a
// per-element reference model written from the requirements.
module pd_pair_shuffle_tb;
    localparam int EW = 64;
    localparam int NE = 8;
    localparam int VW = EW * NE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [VW-1:0] src_a, src_b, old_dst, dst;
    logic [NE-1:0] imm, wmask;
    logic          mask_en, zero_en, bcast;
    logic [1:0]    len, mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    pd_pair_shuffle u_dut (
        .src_a_i   (src_a),
        .src_b_i   (src_b),
        .old_dst_i (old_dst),
        .imm_i     (imm),
        .wmask_i   (wmask),
        .mask_en_i (mask_en),
        .zero_en_i (zero_en),
        .bcast_i   (bcast),
        .len_i     (len),
        .mode_i    (mode),
        .dst_o     (dst)
    );

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int w = 0; w < VW / 32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    // Reference result built element by element from the requirements.
    function automatic logic [VW-1:0] model();
        logic [VW-1:0] r;
        logic sup, msk, above_keep;
        int kl;
        sup = 0; msk = 0; above_keep = 1; kl = 2;
        case (mode)
            2'd0: begin sup = (len == 2'd0); above_keep = 1; kl = 2; end
            2'd1: begin sup = (len == 2'd0); above_keep = 0; kl = 2; end
            2'd2: begin sup = (len == 2'd1); above_keep = 1; kl = 4; end
            default: begin
                sup = (len != 2'd3); msk = 1; above_keep = 0;
                kl = (len == 2'd0) ? 2 : (len == 2'd1) ? 4 : 8;
            end
        endcase
        if (!sup) return old_dst;
        for (int e = 0; e < NE; e++) begin
            int lane, idx;
            logic [EW-1:0] v;
            lane = e / 2;
            idx  = 2 * lane + int'(imm[e]);
            if (e % 2 == 0)      v = src_a[idx*EW +: EW];
            else if (msk && bcast) v = src_b[EW-1:0];
            else                 v = src_b[idx*EW +: EW];
            if (e >= kl)
                r[e*EW +: EW] = above_keep ? old_dst[e*EW +: EW] : '0;
            else if (msk && mask_en && !wmask[e])
                r[e*EW +: EW] = zero_en ? '0 : old_dst[e*EW +: EW];
            else
                r[e*EW +: EW] = v;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] expv);
        n_checks++;
        if (dst !== expv) begin
            n_fails++;
            $display("FAIL %s: mode=%0d len=%0d imm=%02h mask=%02h got=%h exp=%h",
                     tag, mode, len, imm, wmask, dst, expv);
        end
    endtask

    // Drive one operation away from the clock edge, then compare.
    task automatic run(input string tag, input logic [1:0] m, input logic [1:0] l,
                       input logic [NE-1:0] im, input logic [NE-1:0] wm,
                       input logic me, input logic ze, input logic bc);
        @(negedge clk);
        src_a = rand_vec(); src_b = rand_vec(); old_dst = rand_vec();
        mode = m; len = l; imm = im; wmask = wm;
        mask_en = me; zero_en = ze; bcast = bc;
        #1;
        check(tag, model());
    endtask

    initial begin
        src_a = '0; src_b = '0; old_dst = '0; imm = '0; wmask = '0;
        mask_en = 0; zero_en = 0; bcast = 0; len = 2'd0; mode = 2'd0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 reset idle zero", '0);

        // Directed: all-low and all-high selects in every supported mode.
        run("R1 R2 imm00 legacy",   2'd0, 2'd0, 8'h00, 8'h00, 0, 0, 0);
        run("R1 R2 immFF legacy",   2'd0, 2'd0, 8'hFF, 8'h00, 0, 0, 0);
        run("R3 immFF plain128",    2'd1, 2'd0, 8'hFF, 8'h00, 0, 0, 0);
        run("R3 immFC plain128",    2'd1, 2'd0, 8'hFC, 8'h00, 0, 0, 0);
        run("R3 immF0 plain256",    2'd2, 2'd1, 8'hF0, 8'h00, 0, 0, 0);
        run("R1 R2 imm00 m512",     2'd3, 2'd2, 8'h00, 8'hFF, 1, 0, 0);
        run("R1 R2 immFF m512",     2'd3, 2'd2, 8'hFF, 8'hFF, 1, 0, 0);
        run("R4 mask off m512",     2'd3, 2'd2, 8'hA5, 8'h00, 0, 1, 0);
        run("R5 zero mask merge",   2'd3, 2'd2, 8'h3C, 8'h00, 1, 0, 0);
        run("R5 zero mask clear",   2'd3, 2'd2, 8'h3C, 8'h00, 1, 1, 0);
        run("R6 high mask m128",    2'd3, 2'd0, 8'hFF, 8'hFC, 1, 0, 0);
        run("R6 high mask m256",    2'd3, 2'd1, 8'h55, 8'hF0, 1, 1, 0);
        run("R7 bcast m512",        2'd3, 2'd2, 8'hAA, 8'hFF, 1, 0, 1);
        run("R7 bcast ignored p256",2'd2, 2'd1, 8'hAA, 8'h00, 0, 0, 1);
        run("R8 upper clear m256",  2'd3, 2'd1, 8'h0F, 8'h0F, 1, 0, 0);
        run("R9 upper keep legacy", 2'd0, 2'd0, 8'h02, 8'h00, 1, 1, 1);
        run("R10 p256 ignores mask",2'd2, 2'd1, 8'h09, 8'h00, 1, 1, 1);
        run("R11 reserved length",  2'd3, 2'd3, 8'hFF, 8'hFF, 1, 1, 0);
        run("R11 legacy len256",    2'd0, 2'd1, 8'hFF, 8'h00, 0, 0, 0);
        run("R11 plain256 len512",  2'd2, 2'd2, 8'hFF, 8'h00, 0, 0, 0);

        // Random: every mode with every length code, including bad pairs.
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 4; l++) begin
                for (int n = 0; n < 60; n++) begin
                    run("R1 R2 R4 R5 R7 R11 random", 2'(m), 2'(l),
                        NE'($urandom), NE'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom));
                end
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired: got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule